// File: doc/BRIEF.md
# Supply and Rail Supervision Sequencer

This block watches four comparator flags: supply undervoltage, supply overvoltage, regulated-rail undervoltage and regulated-rail overvoltage. It turns them into a shared active-low reset, an enable for the linear regulator and safe-state commands for the valve relay, motor relay, warning lamp, lamp relay and system-enable outputs. All timing runs on a one-cycle `tick` strobe from a 1 ms time base. The flags are resynchronised to the block clock before use.

A filtered supply overvoltage, a rail undervoltage, or a supply undervoltage seen before the first reset release pulls reset low. Reset is released only after the causes have been clear for 52 ticks. Any new cause during that count restarts it from zero. The supply-overvoltage flag is debounced for a number of consecutive ticks in both directions, so short spikes from inductive switch-off are ignored. Each fault class acts on its own set of outputs. A rail overvoltage latches an error flag that only a block reset clears.

The block has no data stream, so it has no valid/ready interface. Every pin is a plain level control or status signal.

Top module: `sup_rail_supervisor`

## Requirements
- R1: `reset_n` is low while the rail undervoltage flag is set, while the filtered supply overvoltage is set, or while the supply undervoltage flag is set before reset has first been released since `rst_n`.
- R2: Once every reset cause of R1 has cleared, `reset_n` stays low for 52 ticks and then goes high. A new cause during that count restarts it from zero.
- R3: The filtered supply overvoltage sets only after the raw flag has been high on 2 consecutive ticks. A pulse that covers only one tick has no effect on any output.
- R4: The filtered supply overvoltage clears only after the raw flag has been low on 2 consecutive ticks.
- R5: While the filtered supply overvoltage is set, the following apply:
  - `reg_en`, `valve_on`, `motor_on` and `enable_ok` are 0.
  - `lamp_relay_on` keeps following `lamp_ctl`.
  - `lamp_on` keeps following the inverse of `lamp_ctl`.
- R6: While the rail undervoltage flag is set, the following apply:
  - `lamp_on` is 1.
  - `lamp_relay_on`, `valve_on`, `motor_on` and `enable_ok` are 0.
  - `reg_en` stays 1 if the supply has no undervoltage.
- R7: A rail overvoltage sets the sticky `err_flag`, which forces the same output state as R6 but does not pull `reset_n` low. `err_flag` stays set after the flag clears, until `rst_n` is asserted.
- R8: After the first reset release, a supply undervoltage alone changes no output.
- R9: When both undervoltage flags are set, `reset_n` is 0, `reg_en` is 0 and `lamp_on` is 1.
- R10: With no fault present, the outputs follow the inputs as follows:
  - `lamp_on` equals the inverse of `lamp_ctl`, so a high `lamp_ctl` turns the lamp off.
  - `lamp_relay_on` equals `lamp_ctl`.
  - `motor_on` equals `motor_req`.
  - `valve_on` and `enable_ok` are 1.
- R11: While `rst_n` is low, the following apply:
  - `reset_n` and `err_flag` are 0 and the release count is cleared.
  - The synchronised flags read as both undervoltages present, giving `reg_en` 0 and `lamp_on` 1, with the relay outputs and `enable_ok` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | One-cycle strobe marking each 1 ms time-base step |
| sup_uv_raw | input | 1 | Supply undervoltage comparator flag |
| sup_ov_raw | input | 1 | Supply overvoltage comparator flag |
| rail_uv_raw | input | 1 | Regulated-rail undervoltage comparator flag |
| rail_ov_raw | input | 1 | Regulated-rail overvoltage comparator flag |
| lamp_ctl | input | 1 | Lamp control; high switches the lamp off and the lamp relay on |
| motor_req | input | 1 | Motor relay request; high asks for the relay on |
| reset_n | output | 1 | Shared active-low system reset |
| reg_en | output | 1 | Regulator enable |
| lamp_on | output | 1 | Warning lamp on command |
| lamp_relay_on | output | 1 | Lamp relay on command |
| valve_on | output | 1 | Valve relay on command |
| motor_on | output | 1 | Motor relay on command |
| enable_ok | output | 1 | System enable; low reports an error |
| err_flag | output | 1 | Sticky rail-overvoltage error |

## Verification
The bench builds the block with its defaults: 52 release ticks, a 2-tick overvoltage filter and 2 synchroniser stages. It issues a tick every fourth clock, which brings a full 52-tick release and a restarted release within a few hundred cycles. With that spacing, a raw pulse four clocks wide covers exactly one tick, so the single-tick rejection of the filter can be exercised deterministically. Reset-release checks sample one tick early and one tick late around the expected release, which tolerates the phase between a flag change and the next tick.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Synchronised comparator flags, one bit per monitored condition
  typedef struct packed {
    logic sup_uv;
    logic sup_ov;
    logic rail_uv;
    logic rail_ov;
  } sup_flags_t;

  localparam int unsigned NUM_FLAGS = $bits(sup_flags_t);

  // Value the synchroniser holds in reset: both undervoltages present
  localparam sup_flags_t FLAGS_RESET = '{sup_uv: 1'b1, sup_ov: 1'b0,
                                         rail_uv: 1'b1, rail_ov: 1'b0};

  // Output command bundle
  typedef struct packed {
    logic reg_en;
    logic lamp_on;
    logic lamp_relay_on;
    logic valve_on;
    logic motor_on;
    logic enable_ok;
  } sup_cmd_t;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RESET_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/sup_ov_filter.sv
module sup_ov_filter #(
  parameter int unsigned FILT_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ov_in,
  output logic ov_filt
);
  localparam int unsigned CNT_W = (FILT_TICKS < 2) ? 1 : $clog2(FILT_TICKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_TICKS - 1);

  logic [CNT_W-1:0] agree_cnt;
  logic             state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= 1'b0;
      agree_cnt <= '0;
    end else if (ov_in == state_q) begin
      agree_cnt <= '0;
    end else if (tick) begin
      if (agree_cnt == CNT_LAST) begin
        state_q   <= ov_in;
        agree_cnt <= '0;
      end else begin
        agree_cnt <= agree_cnt + 1'b1;
      end
    end
  end

  assign ov_filt = state_q;

  // R3/R4: the filtered level moves only on a tick
  assert_ov_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_filt != $past(ov_filt)) |-> $past(tick));

  // R3: a rise follows a raw flag that was high
  assert_ov_rise_from_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_filt) |-> $past(ov_in));

  // R4: a fall follows a raw flag that was low
  assert_ov_fall_from_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ov_filt) |-> !$past(ov_in));
endmodule

// File: rtl/sup_reset_seq.sv
module sup_reset_seq #(
  parameter int unsigned RELEASE_TICKS = 52
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sup_uv,
  input  logic rail_uv,
  input  logic sup_ov_filt,
  output logic reset_n
);
  localparam int unsigned CNT_W = $clog2(RELEASE_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RELEASE_TICKS - 1);

  logic [CNT_W-1:0] rel_cnt;
  logic             rst_q;
  logic             powered_q;
  logic             cause;

  // Supply undervoltage locks reset only until the first release
  assign cause = rail_uv | sup_ov_filt | (sup_uv & ~powered_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q     <= 1'b0;
      powered_q <= 1'b0;
      rel_cnt   <= '0;
    end else if (cause) begin
      rst_q   <= 1'b0;
      rel_cnt <= '0;
    end else if (!rst_q && tick) begin
      if (rel_cnt == CNT_LAST) begin
        rst_q     <= 1'b1;
        powered_q <= 1'b1;
        rel_cnt   <= '0;
      end else begin
        rel_cnt <= rel_cnt + 1'b1;
      end
    end
  end

  assign reset_n = rst_q;

  // R1: any cause pulls reset low on the next edge
  assert_reset_on_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> !reset_n);

  // R2: release only from a cause-free cycle on a tick
  assert_release_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n) |-> ($past(!cause) && $past(tick)));

  // R8: supply undervoltage alone never drops an established reset release
  assert_uv_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_n && !rail_uv && !sup_ov_filt) |=> reset_n);
endmodule

// File: rtl/sup_out_map.sv
module sup_out_map
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sup_flags_t flags,
  input  logic       sup_ov_filt,
  input  logic       lamp_ctl,
  input  logic       motor_req,
  output sup_cmd_t   cmd,
  output logic       err_flag
);
  logic err_q;
  logic safe;
  logic relays_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            err_q <= 1'b0;
    else if (flags.rail_ov) err_q <= 1'b1;
  end

  // Rail faults take priority; supply overvoltage blocks the drivers only
  assign safe         = flags.rail_uv | err_q;
  assign relays_block = safe | sup_ov_filt;

  always_comb begin
    cmd.reg_en        = ~sup_ov_filt & ~(flags.sup_uv & flags.rail_uv);
    cmd.lamp_on       = safe ? 1'b1 : ~lamp_ctl;
    cmd.lamp_relay_on = safe ? 1'b0 : lamp_ctl;
    cmd.valve_on      = ~relays_block;
    cmd.motor_on      = ~relays_block & motor_req;
    cmd.enable_ok     = ~relays_block;
  end

  assign err_flag = err_q;

  // R7: error flag is sticky
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_flag) |-> err_flag);

  // R6/R7: rail faults give the full safe state
  assert_safe_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.rail_uv || err_flag) |-> (cmd.lamp_on && !cmd.lamp_relay_on &&
                                     !cmd.valve_on && !cmd.motor_on && !cmd.enable_ok));

  // R5: supply overvoltage removes the regulator and the relays
  assert_ov_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sup_ov_filt |-> (!cmd.reg_en && !cmd.valve_on && !cmd.motor_on));
endmodule

// File: rtl/sup_rail_supervisor.sv
module sup_rail_supervisor
  import sup_pkg::*;
#(
  parameter int unsigned RELEASE_TICKS = 52,
  parameter int unsigned OV_FILT_TICKS = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sup_uv_raw,
  input  logic sup_ov_raw,
  input  logic rail_uv_raw,
  input  logic rail_ov_raw,
  input  logic lamp_ctl,
  input  logic motor_req,
  output logic reset_n,
  output logic reg_en,
  output logic lamp_on,
  output logic lamp_relay_on,
  output logic valve_on,
  output logic motor_on,
  output logic enable_ok,
  output logic err_flag
);
  sup_flags_t raw_flags;
  sup_flags_t sync_flags;
  sup_cmd_t   cmd;
  logic       sup_ov_filt;

  assign raw_flags = '{sup_uv: sup_uv_raw, sup_ov: sup_ov_raw,
                       rail_uv: rail_uv_raw, rail_ov: rail_ov_raw};

  sup_sync #(
    .WIDTH    (NUM_FLAGS),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(FLAGS_RESET)
  ) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_flags),
    .q    (sync_flags)
  );

  sup_ov_filter #(
    .FILT_TICKS(OV_FILT_TICKS)
  ) i_ov_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .ov_in  (sync_flags.sup_ov),
    .ov_filt(sup_ov_filt)
  );

  sup_reset_seq #(
    .RELEASE_TICKS(RELEASE_TICKS)
  ) i_reset_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .sup_uv     (sync_flags.sup_uv),
    .rail_uv    (sync_flags.rail_uv),
    .sup_ov_filt(sup_ov_filt),
    .reset_n    (reset_n)
  );

  sup_out_map i_out_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags      (sync_flags),
    .sup_ov_filt(sup_ov_filt),
    .lamp_ctl   (lamp_ctl),
    .motor_req  (motor_req),
    .cmd        (cmd),
    .err_flag   (err_flag)
  );

  assign reg_en        = cmd.reg_en;
  assign lamp_on       = cmd.lamp_on;
  assign lamp_relay_on = cmd.lamp_relay_on;
  assign valve_on      = cmd.valve_on;
  assign motor_on      = cmd.motor_on;
  assign enable_ok     = cmd.enable_ok;

  // R9: both undervoltages keep the regulator off
  assert_double_uv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_flags.sup_uv && sync_flags.rail_uv) |-> (!reg_en && lamp_on));

  // R7: rail overvoltage alone does not drop an established reset release
  assert_rail_ov_no_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_n && !sync_flags.rail_uv && !sup_ov_filt) |=> reset_n);
endmodule

// File: tb/test_sup_rail_supervisor.sv
`timescale 1ns/1ps
module test_sup_rail_supervisor;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [1:0] tick_div = '0;
  logic sup_uv_raw = 1'b1, sup_ov_raw = 1'b0, rail_uv_raw = 1'b1, rail_ov_raw = 1'b0;
  logic lamp_ctl = 1'b0, motor_req = 1'b0;
  logic reset_n, reg_en, lamp_on, lamp_relay_on, valve_on, motor_on, enable_ok, err_flag;

  item_t exp_q[$];
  event  sample_ev;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  always #2.5 clk = ~clk;

  // Tick every fourth clock
  always @(posedge clk) begin
    tick_div <= tick_div + 2'd1;
    tick     <= (tick_div == 2'd3);
  end

  sup_rail_supervisor i_sup_rail_supervisor (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .sup_uv_raw(sup_uv_raw), .sup_ov_raw(sup_ov_raw),
    .rail_uv_raw(rail_uv_raw), .rail_ov_raw(rail_ov_raw),
    .lamp_ctl(lamp_ctl), .motor_req(motor_req),
    .reset_n(reset_n), .reg_en(reg_en), .lamp_on(lamp_on),
    .lamp_relay_on(lamp_relay_on), .valve_on(valve_on), .motor_on(motor_on),
    .enable_ok(enable_ok), .err_flag(err_flag)
  );

  // Bit order: reset_n reg_en lamp_on lamp_relay_on valve_on motor_on enable_ok err_flag
  task automatic expect_now(input string tag, input logic [7:0] exp);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    exp_q.push_back(it);
    -> sample_ev;
    #0.1;
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = exp_q.pop_front();
        act = {reset_n, reg_en, lamp_on, lamp_relay_on, valve_on, motor_on, enable_ok, err_flag};
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    wclk(3);
    expect_now("R11 reset state", 8'b0010_0000);
    rst_n = 1'b1;
    wclk(5);
    expect_now("R9 both undervoltage", 8'b0010_0000);

    rail_uv_raw = 1'b0; lamp_ctl = 1'b1; motor_req = 1'b1;
    wclk(300);
    expect_now("R1 supply uv lockout at power-up", 8'b0101_1110);

    sup_uv_raw = 1'b0;
    wclk(200);
    expect_now("R2 reset held during release count", 8'b0101_1110);
    wclk(16);
    expect_now("R2 reset released", 8'b1101_1110);

    sup_uv_raw = 1'b1;
    wclk(300);
    expect_now("R8 supply uv after release ignored", 8'b1101_1110);
    sup_uv_raw = 1'b0;

    lamp_ctl = 1'b0; motor_req = 1'b0;
    wclk(2);
    expect_now("R10 normal follow", 8'b1110_1010);

    sup_ov_raw = 1'b1;
    wclk(4);
    sup_ov_raw = 1'b0;
    wclk(20);
    expect_now("R3 single-tick overvoltage ignored", 8'b1110_1010);

    sup_ov_raw = 1'b1; lamp_ctl = 1'b1; motor_req = 1'b1;
    wclk(20);
    expect_now("R5 supply overvoltage state", 8'b0001_0000);
    lamp_ctl = 1'b0;
    wclk(2);
    expect_now("R5 lamp relay follows during overvoltage", 8'b0010_0000);

    sup_ov_raw = 1'b0;
    wclk(3);
    expect_now("R4 overvoltage clear filtered", 8'b0010_0000);
    wclk(20);
    expect_now("R4 overvoltage cleared, reset counting", 8'b0110_1110);
    wclk(216);
    expect_now("R2 release after overvoltage", 8'b1110_1110);

    rail_uv_raw = 1'b1;
    wclk(4);
    expect_now("R6 rail undervoltage safe state", 8'b0110_0000);

    rail_uv_raw = 1'b0;
    wclk(120);
    rail_uv_raw = 1'b1;
    wclk(4);
    rail_uv_raw = 1'b0;
    wclk(200);
    expect_now("R2 count restarted by new fault", 8'b0110_1110);
    wclk(16);
    expect_now("R2 release after restart", 8'b1110_1110);

    rail_ov_raw = 1'b1;
    wclk(4);
    expect_now("R7 rail overvoltage error", 8'b1110_0001);
    rail_ov_raw = 1'b0;
    wclk(40);
    expect_now("R7 error flag sticky", 8'b1110_0001);

    rst_n = 1'b0;
    wclk(3);
    expect_now("R11 reset clears error", 8'b0010_0000);
    rst_n = 1'b1;
    wclk(5);
    expect_now("R11 after reset, release pending", 8'b0110_1110);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule